// File: doc/BRIEF.md
# Bi-Quinary Decimal Digit Adder

This block adds decimal numbers held in bi-quinary form. Each digit travels on seven wires: a group of five wires, one-hot, that carries the remainder of the digit modulo five, and a pair, also one-hot, that says whether the digit has a five in it. A carry between digits is also a one-hot pair, so every signal that enters or leaves a digit is a one-of-N code. The whole block is combinational. It is built only from AND terms that feed OR trees, and it has no inverters. Any output wire that is low is low because none of its product terms holds.

Inside each digit a small control stage takes the incoming carry and rotates addend A's quinary group up by one place. The wire that falls off the top end is passed on as a separate "wrapped to five" strobe. A datapath stage then sums the rotated group with addend B's group through a 5x5 product matrix. It adds the two binary pairs and the five produced on the quinary side through a 2x2x2 product cube, and this gives the binary part of the sum and the carry-out pair. Digits are chained by a generate loop, so a word of `DIGITS` decimal digits ripples its carry from the least significant digit to the most significant one. Tying the carry-in to "no carry" makes the block a half adder.

Top module: `bq_adder`

## Requirements
- R1: Each digit d occupies quinary wires [5d+4:5d], where wire 5d+k high means remainder k, and binary wires [2d+1:2d], where 2'b01 means no five and 2'b10 means five. The carry pairs use 2'b01 for no carry and 2'b10 for carry. Sum outputs use the same layout as the addends.
- R2: For valid one-hot inputs, the sum word equals (A + B + carry-in) modulo 10^DIGITS, encoded as in R1.
- R3: The carry-out pair is 2'b10 exactly when A + B + carry-in reaches 10^DIGITS, and 2'b01 otherwise.
- R4: For valid one-hot inputs, every quinary group, every binary pair and the carry-out pair of the result has exactly one wire high.
- R5: With carry-in at 2'b01 the block acts as a half adder, and the result is A + B with no added one.
- R6: When carry-in is 2'b10 and addend A's digit has remainder four (digit 4 or 9), the rotation wraps: the result's quinary remainder is that of B, and the digit gains a five on its binary side.
- R7: The carry-out of digit d is the carry-in of digit d+1, so one carry can ripple through every digit of the word (for example 99 + 00 + carry gives 00 with carry-out set when DIGITS is 2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| addAQui | input | 5*DIGITS | Addend A quinary groups, one-hot per digit |
| addABin | input | 2*DIGITS | Addend A binary pairs (01 = +0, 10 = +5) |
| addBQui | input | 5*DIGITS | Addend B quinary groups, one-hot per digit |
| addBBin | input | 2*DIGITS | Addend B binary pairs |
| carryIn | input | 2 | Carry into the least significant digit (01 none, 10 carry) |
| sumQui | output | 5*DIGITS | Sum quinary groups |
| sumBin | output | 2*DIGITS | Sum binary pairs |
| carryOut | output | 2 | Carry out of the most significant digit |

## Verification
The case that is hardest to reach is the wrap. A carry is rotated into a digit whose A remainder is already four, so the five has to reach the binary cube through the wrap strobe and not through the quinary overflow. A carry that ripples through every digit at once is just as hard, because it needs a carry-in together with every lower digit summing to exactly nine. The stimulus applies the full 10x10x2 digit space on the low digit, which covers each wrap case. It then drives word pairs such as 99 + 00 with carry, 45 + 54 with carry and 50 + 49 with carry, so that the carry passes through every stage. A sweep of word pairs follows, some with carry and some without.

// File: rtl/bq_pkg.sv
package bq_pkg;
  localparam int QW = 5;   // quinary group width
  localparam int BW = 2;   // binary pair width
  localparam int NO = 0;   // pair index for "none" / "+0"
  localparam int YES = 1;  // pair index for "carry" / "+5"

  // strobes handed from the carry-rotation control to the digit datapath
  typedef struct packed {
    logic [QW-1:0] qRot;     // addend A quinary after carry rotation
    logic          wrapFive; // top wire rotated off: contributes a five
    logic          noWrap;   // positive-logic complement of wrapFive
  } rotStrobe_t;
endpackage

// File: rtl/bq_carry_rot.sv
module bq_carry_rot
  import bq_pkg::*;
(
  input  logic [QW-1:0] quiA,
  input  logic [BW-1:0] cin,
  output rotStrobe_t    strobe
);
  always_comb begin
    for (int i = 0; i < QW; i++) begin
      strobe.qRot[i] = (quiA[i] & cin[NO]) | (quiA[(i + QW - 1) % QW] & cin[YES]);
    end
    strobe.wrapFive = quiA[QW-1] & cin[YES];
    strobe.noWrap   = cin[NO] | (cin[YES] & (|quiA[QW-2:0]));
  end

  always_comb begin
    if ($onehot(quiA) && $onehot(cin)) begin
      // R5
      half_pass_chk: assert (!cin[NO] || strobe.qRot == quiA)
        else $error("rotation altered A with no carry");
      // R6
      wrap_rot_chk: assert (!strobe.wrapFive || (strobe.qRot[0] && !strobe.noWrap))
        else $error("wrap strobe inconsistent with rotated group");
      // R4
      rot_onehot_chk: assert ($onehot(strobe.qRot) && (strobe.wrapFive != strobe.noWrap))
        else $error("rotation output not one-hot");
    end
  end
endmodule

// File: rtl/bq_digit_dp.sv
module bq_digit_dp
  import bq_pkg::*;
(
  input  rotStrobe_t    strobe,
  input  logic [QW-1:0] quiB,
  input  logic [BW-1:0] binA,
  input  logic [BW-1:0] binB,
  output logic [QW-1:0] sumQ,
  output logic [BW-1:0] sumB,
  output logic [BW-1:0] cout
);
  logic [1:0] five;  // one-hot: [1] a five comes from the quinary side

  // quinary 5x5 product matrix
  always_comb begin : quiTree
    logic term;
    logic ovr;
    logic noOvr;
    sumQ  = '0;
    ovr   = 1'b0;
    noOvr = 1'b0;
    for (int i = 0; i < QW; i++) begin
      for (int j = 0; j < QW; j++) begin
        term = strobe.qRot[i] & quiB[j];
        sumQ[(i + j) % QW] = sumQ[(i + j) % QW] | term;
        if (i + j >= QW) ovr = ovr | term;
        else             noOvr = noOvr | term;
      end
    end
    five[1] = ovr | strobe.wrapFive;
    five[0] = noOvr & strobe.noWrap;
  end

  // binary 2x2x2 product cube
  always_comb begin : binTree
    logic term;
    sumB = '0;
    cout = '0;
    for (int x = 0; x < BW; x++) begin
      for (int y = 0; y < BW; y++) begin
        for (int z = 0; z < 2; z++) begin
          term = binA[x] & binB[y] & five[z];
          sumB[(x + y + z) % 2] = sumB[(x + y + z) % 2] | term;
          if (x + y + z >= 2) cout[YES] = cout[YES] | term;
          else                cout[NO]  = cout[NO] | term;
        end
      end
    end
  end

  always_comb begin
    if ($onehot(strobe.qRot) && $onehot(quiB)) begin
      // R4
      sumq_onehot_chk: assert ($onehot(sumQ))
        else $error("sum quinary not one-hot");
      if ($onehot(binA) && $onehot(binB) && (strobe.wrapFive != strobe.noWrap)) begin
        // R4
        sumb_onehot_chk: assert ($onehot(sumB))
          else $error("sum binary not one-hot");
        // R3
        cout_onehot_chk: assert ($onehot(cout) && !(cout[YES] && !binA[YES] && !binB[YES]))
          else $error("carry-out malformed");
      end
    end
  end
endmodule

// File: rtl/bq_adder.sv
module bq_adder
  import bq_pkg::*;
#(
  parameter int DIGITS = 2
) (
  input  logic [QW*DIGITS-1:0] addAQui,
  input  logic [BW*DIGITS-1:0] addABin,
  input  logic [QW*DIGITS-1:0] addBQui,
  input  logic [BW*DIGITS-1:0] addBBin,
  input  logic [BW-1:0]        carryIn,
  output logic [QW*DIGITS-1:0] sumQui,
  output logic [BW*DIGITS-1:0] sumBin,
  output logic [BW-1:0]        carryOut
);
  logic [BW-1:0] chainC [0:DIGITS];

  assign chainC[0] = carryIn;

  for (genvar d = 0; d < DIGITS; d++) begin : gDigit
    rotStrobe_t strobe;

    bq_carry_rot uRot (
      .quiA   (addAQui[QW*d +: QW]),
      .cin    (chainC[d]),
      .strobe (strobe)
    );

    bq_digit_dp uDp (
      .strobe (strobe),
      .quiB   (addBQui[QW*d +: QW]),
      .binA   (addABin[BW*d +: BW]),
      .binB   (addBBin[BW*d +: BW]),
      .sumQ   (sumQui[QW*d +: QW]),
      .sumB   (sumBin[BW*d +: BW]),
      .cout   (chainC[d+1])
    );
  end

  assign carryOut = chainC[DIGITS];
endmodule

// File: tb/tb_bq_adder.sv
module tb_bq_adder;
  localparam int DIGITS = 2;
  localparam int NQ = 5 * DIGITS;
  localparam int NB = 2 * DIGITS;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;  // 50 MHz

  logic [NQ-1:0] addAQui, addBQui, sumQui;
  logic [NB-1:0] addABin, addBBin, sumBin;
  logic [1:0]    carryIn, carryOut;

  bq_adder #(.DIGITS(DIGITS)) dut (
    .addAQui(addAQui), .addABin(addABin),
    .addBQui(addBQui), .addBBin(addBBin),
    .carryIn(carryIn),
    .sumQui(sumQui), .sumBin(sumBin), .carryOut(carryOut)
  );

  typedef struct {
    logic [NQ-1:0] q;
    logic [NB-1:0] b;
    logic [1:0]    c;
    int            a;
    int            bv;
    int            ci;
    string         tag;
  } item_t;

  item_t expQ[$];
  int compared = 0;
  int mismatched = 0;
  bit driveDone = 0;

  function automatic void encWord(input int v, output logic [NQ-1:0] q, output logic [NB-1:0] b);
    int rest;
    q = '0;
    b = '0;
    rest = v;
    for (int d = 0; d < DIGITS; d++) begin
      q[5*d + (rest % 10) % 5] = 1'b1;
      b[2*d + (((rest % 10) >= 5) ? 1 : 0)] = 1'b1;
      rest = rest / 10;
    end
  endfunction

  function automatic int wordMod();
    int m = 1;
    for (int d = 0; d < DIGITS; d++) m = m * 10;
    return m;
  endfunction

  task automatic drive(input int a, input int b, input int ci, input string tag);
    item_t it;
    logic [NQ-1:0] q;
    logic [NB-1:0] bb;
    int total;
    @(negedge clk);
    encWord(a, q, bb);
    addAQui = q; addABin = bb;
    encWord(b, q, bb);
    addBQui = q; addBBin = bb;
    carryIn = ci ? 2'b10 : 2'b01;
    total = a + b + ci;
    encWord(total % wordMod(), it.q, it.b);
    it.c = (total >= wordMod()) ? 2'b10 : 2'b01;  // R3
    it.a = a; it.bv = b; it.ci = ci; it.tag = tag;
    expQ.push_back(it);
  endtask

  // monitor / scoreboard
  always @(posedge clk) begin
    if (!rst && expQ.size() > 0) begin
      item_t it;
      bit oh;
      it = expQ.pop_front();
      compared++;
      if (sumQui !== it.q || sumBin !== it.b || carryOut !== it.c) begin
        mismatched++;
        $display("FAIL %s: %0d+%0d+%0d got q=%b b=%b c=%b expected q=%b b=%b c=%b",
                 it.tag, it.a, it.bv, it.ci, sumQui, sumBin, carryOut, it.q, it.b, it.c);
      end
      // R4: one-hot on every output group
      oh = $onehot(carryOut);
      for (int d = 0; d < DIGITS; d++) begin
        if (!$onehot(sumQui[5*d +: 5]) || !$onehot(sumBin[2*d +: 2])) oh = 0;
      end
      compared++;
      if (!oh) begin
        mismatched++;
        $display("FAIL R4: %0d+%0d+%0d got q=%b b=%b c=%b expected one-hot groups",
                 it.a, it.bv, it.ci, sumQui, sumBin, carryOut);
      end
    end
  end

  initial begin
    addAQui = '0; addABin = '0; addBQui = '0; addBBin = '0; carryIn = 2'b01;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // R1: zero word plus zero, no carry
    drive(0, 0, 0, "R1");
    // exhaustive low digit: R2/R3 always, R5 without carry, R6 on wraps
    for (int a = 0; a < 10; a++) begin
      for (int b = 0; b < 10; b++) begin
        for (int c = 0; c < 2; c++) begin
          if (c == 0)                         drive(a, b, c, "R5");
          else if ((a % 5) == 4)              drive(a, b, c, "R6");
          else if (a + b + c >= 10)           drive(a, b, c, "R3");
          else                                drive(a, b, c, "R2");
        end
      end
    end
    // R7: carries rippling through every digit
    drive(99, 0, 1, "R7");
    drive(45, 54, 1, "R7");
    drive(50, 49, 1, "R7");
    drive(99, 99, 1, "R7");
    drive(9, 90, 1, "R7");
    // R2: word sweep
    for (int a = 3; a < 100; a += 7) begin
      for (int b = 1; b < 100; b += 13) begin
        drive(a, b, (a + b) % 2, "R2");
      end
    end
    driveDone = 1;
  end

  initial begin
    int cycles = 0;
    while (!(driveDone && expQ.size() == 0) && cycles < 20000) begin
      @(posedge clk);
      cycles++;
    end
    if (cycles >= 20000) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: run hung, got %0d cycles expected completion", cycles);
    end
    @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule